// File: doc/BRIEF.md
# Multi-Link Stream Port Bridge

This block is a memory-mapped peripheral that joins a simple CPU load/store bus to as many as eight outgoing and eight incoming 32-bit stream links. Every implemented link has a private FIFO. A bus write to a link's data word queues that word for the outgoing link. A bus read from a link's data word takes the oldest word that the incoming link has delivered.

Data accesses are blocking. The bus acknowledge is withheld until the addressed FIFO can serve the access. The number of links in each direction and the FIFO depth in each direction are parameters. A read-only part of the control word reports these parameters. A single writable enable bit starts the links. While the enable bit is low, the links are held empty and idle.

The bus uses a held request. The master raises `bus_req` together with the write flag, the address and the write data, and keeps all of them steady until it sees `bus_ack`. It drops the request in the cycle that follows the acknowledge.

Top module: `stream_link_bridge`

## Requirements
- R1: After reset, the enable bit is 0, `bus_ack` is low, and all `tx_valid` and `rx_ready` bits are low. The control word then reads `{1'b0, 15'b0, log2(TX_DEPTH)[3:0], log2(RX_DEPTH)[3:0], N_TX[3:0], N_RX[3:0]}` at byte offset 0x00.
- R2: A write to offset 0x00 changes only bit 31, which is the enable. Bits 30:0 keep their configuration values no matter what data is written.
- R3: Offsets 0x04, 0x08, 0x0C, 0x14, 0x18 and 0x1C always read as zero. Writes to these offsets have no effect.
- R4: A write to offset 0x20+4*i queues a word on TX link i. TX link i presents its words in write order on `tx_data[32*i+:32]`, with `tx_valid[i]` high. A word leaves only in a cycle where `tx_valid[i]` and `tx_ready[i]` are both high. Data and valid stay stable while ready is low.
- R5: `rx_ready[i]` is high while RX FIFO i has space and low when it is full. A word is taken only when `rx_valid[i]` and `rx_ready[i]` are both high. A read of offset 0x20+4*i returns the stored words in arrival order.
- R6: A read of an empty implemented RX link is not acknowledged until a word arrives. The read then returns that word.
- R7: A write to a full implemented TX link is not acknowledged until a word has left that link. The written word is then queued behind the others.
- R8: The status word at offset 0x10 is `{tx_half[7:0], rx_half[7:0], tx_free[7:0], rx_avail[7:0]}`. Half means 2*fill >= depth. Free means fill < depth. Avail means fill > 0. The bits of unimplemented links read 0.
- R9: Links at or above N_TX or N_RX drive `tx_valid`, `tx_data` and `rx_ready` low. Accesses to their data words are acknowledged after one cycle. Such reads return zero.
- R10: While the enable bit is low, all FIFOs are held empty and all `tx_valid` and `rx_ready` bits are low. Data accesses are acknowledged after one cycle: reads return zero and writes are dropped.
- R11: `bus_ack` is a one-cycle pulse. It comes at the earliest one cycle after the request, and register accesses always get it after exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset bits 5:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | One-cycle access acknowledge |
| tx_data | output | 256 | Outgoing data, link i at bits 32*i+31:32*i |
| tx_valid | output | 8 | Outgoing word valid, one bit per link |
| tx_ready | input | 8 | Outgoing sink ready, one bit per link |
| rx_data | input | 256 | Incoming data, link i at bits 32*i+31:32*i |
| rx_valid | input | 8 | Incoming word valid, one bit per link |
| rx_ready | output | 8 | Incoming space available, one bit per link |

## Verification
The hardest situations to reach from the ports are a bus access that stays held because its FIFO is full or empty, followed by a link-side handshake that frees the FIFO in the middle of that access.

The bench first fills a TX link by holding its ready low, or leaves an RX link empty. It then runs the blocked bus access in parallel with a delayed branch that pulses the link handshake. It checks three things: the access stays unacknowledged for several cycles, it completes with the right word, and word order is kept across the stall.

// File: rtl/stream_link_bridge.sv
module stream_link_bridge #(
  parameter int N_TX     = 8,
  parameter int N_RX     = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_req,
  input  logic         bus_we,
  input  logic [5:2]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  output logic         bus_ack,
  output logic [255:0] tx_data,
  output logic [7:0]   tx_valid,
  input  logic [7:0]   tx_ready,
  input  logic [255:0] rx_data,
  input  logic [7:0]   rx_valid,
  output logic [7:0]   rx_ready
);
  localparam int TX_LG = $clog2(TX_DEPTH);
  localparam int RX_LG = $clog2(RX_DEPTH);
  localparam int TX_IW = (TX_LG > 0) ? TX_LG : 1;
  localparam int RX_IW = (RX_LG > 0) ? RX_LG : 1;
  localparam int TX_CW = TX_LG + 1;
  localparam int RX_CW = RX_LG + 1;
  localparam logic [7:0] TX_MASK = 8'((9'd1 << N_TX) - 9'd1);
  localparam logic [7:0] RX_MASK = 8'((9'd1 << N_RX) - 9'd1);

  logic        en;
  logic [7:0]  tx_free, tx_half, rx_avail, rx_half;
  logic [31:0] rx_head [8];
  logic [31:0] rd_val;

  wire       is_data = bus_addr[5];
  wire [2:0] lk      = bus_addr[4:2];
  wire wr_ok   = !en || !TX_MASK[lk] || tx_free[lk];
  wire rd_ok   = !en || !RX_MASK[lk] || rx_avail[lk];
  wire serve   = bus_req && !bus_ack && (!is_data || (bus_we ? wr_ok : rd_ok));
  wire data_wr = serve && is_data && bus_we && en;
  wire data_rd = serve && is_data && !bus_we && en;

  for (genvar i = 0; i < 8; i++) begin : g_link
    if (i < N_TX) begin : g_tx
      logic [31:0]      mem [TX_DEPTH];
      logic [TX_IW-1:0] wp, rp;
      logic [TX_CW-1:0] cnt;
      wire push = data_wr && (lk == 3'(i));
      wire pop  = tx_valid[i] && tx_ready[i];
      always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
          wp <= '0; rp <= '0; cnt <= '0;
        end else begin
          if (push) wp <= (wp == TX_IW'(TX_DEPTH - 1)) ? '0 : wp + 1'b1;
          if (pop)  rp <= (rp == TX_IW'(TX_DEPTH - 1)) ? '0 : rp + 1'b1;
          cnt <= cnt + TX_CW'(push) - TX_CW'(pop);
        end
      end
      always_ff @(posedge clk) if (push) mem[wp] <= bus_wdata;
      assign tx_valid[i]        = en && (cnt != '0);
      assign tx_data[32*i+:32]  = mem[rp];
      assign tx_free[i]         = cnt != TX_CW'(TX_DEPTH);
      assign tx_half[i]         = {cnt, 1'b0} >= (TX_CW + 1)'(TX_DEPTH);
    end else begin : g_tx_off
      assign tx_valid[i]       = 1'b0;
      assign tx_data[32*i+:32] = '0;
      assign tx_free[i]        = 1'b0;
      assign tx_half[i]        = 1'b0;
    end

    if (i < N_RX) begin : g_rx
      logic [31:0]      mem [RX_DEPTH];
      logic [RX_IW-1:0] wp, rp;
      logic [RX_CW-1:0] cnt;
      wire push = rx_valid[i] && rx_ready[i];
      wire pop  = data_rd && (lk == 3'(i));
      always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
          wp <= '0; rp <= '0; cnt <= '0;
        end else begin
          if (push) wp <= (wp == RX_IW'(RX_DEPTH - 1)) ? '0 : wp + 1'b1;
          if (pop)  rp <= (rp == RX_IW'(RX_DEPTH - 1)) ? '0 : rp + 1'b1;
          cnt <= cnt + RX_CW'(push) - RX_CW'(pop);
        end
      end
      always_ff @(posedge clk) if (push) mem[wp] <= rx_data[32*i+:32];
      assign rx_ready[i] = en && (cnt != RX_CW'(RX_DEPTH));
      assign rx_head[i]  = mem[rp];
      assign rx_avail[i] = cnt != '0;
      assign rx_half[i]  = {cnt, 1'b0} >= (RX_CW + 1)'(RX_DEPTH);
    end else begin : g_rx_off
      assign rx_ready[i] = 1'b0;
      assign rx_head[i]  = '0;
      assign rx_avail[i] = 1'b0;
      assign rx_half[i]  = 1'b0;
    end
  end

  always_comb begin
    rd_val = '0;
    if (is_data) begin
      if (en) rd_val = rx_head[lk];
    end else begin
      case (lk)
        3'd0: rd_val = {en, 15'b0, 4'(TX_LG), 4'(RX_LG), 4'(N_TX), 4'(N_RX)};
        3'd4: rd_val = {tx_half, rx_half, tx_free, rx_avail};
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (serve && bus_we && !is_data && lk == 3'd0) en <= bus_wdata[31];
      bus_ack   <= serve;
      bus_rdata <= (serve && !bus_we) ? rd_val : '0;
    end
  end
endmodule

// File: rtl/stream_link_bridge_chk.sv
module stream_link_bridge_chk #(
  parameter int N_TX = 8,
  parameter int N_RX = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         bus_req,
  input logic         bus_ack,
  input logic [255:0] tx_data,
  input logic [7:0]   tx_valid,
  input logic [7:0]   tx_ready,
  input logic [7:0]   rx_ready
);
  localparam logic [7:0] TX_MASK = 8'((9'd1 << N_TX) - 9'd1);
  localparam logic [7:0] RX_MASK = 8'((9'd1 << N_RX) - 9'd1);

  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  // R11
  ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_req));

  // R10
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (tx_valid == 8'd0 && rx_ready == 8'd0));

  // R9
  unimpl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_valid & ~TX_MASK) == 8'd0) && ((rx_ready & ~RX_MASK) == 8'd0));

  for (genvar i = 0; i < 8; i++) begin : g_hold
    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tx_valid[i] && !tx_ready[i]) |=>
        (!en || (tx_valid[i] && $stable(tx_data[32*i+:32]))));
  end
endmodule

bind stream_link_bridge stream_link_bridge_chk #(.N_TX(N_TX), .N_RX(N_RX)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .bus_req(bus_req), .bus_ack(bus_ack),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_ready(rx_ready)
);

// File: tb/stream_link_bridge_tb_top.sv
module stream_link_bridge_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_req = 1'b0, bus_we = 1'b0;
  logic [5:2]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0, bus_rdata;
  logic         bus_ack;
  logic [255:0] tx_data, rx_data = '0;
  logic [7:0]   tx_valid, tx_ready = '0, rx_valid = '0, rx_ready;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  stream_link_bridge #(.N_TX(3), .N_RX(2), .TX_DEPTH(4), .RX_DEPTH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [5:0] a, input logic [31:0] d,
                     output logic [31:0] q, output int cyc);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a[5:2]; bus_wdata = d; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!bus_ack && cyc < 1000);
    q = bus_rdata; bus_req = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] q);
    int c;
    bus(1'b0, a, '0, q, c);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    logic [31:0] q; int c;
    bus(1'b1, a, d, q, c);
  endtask

  task automatic rx_send(input int l, input logic [31:0] d);
    @(negedge clk);
    rx_valid[l] = 1'b1; rx_data[32*l+:32] = d;
    while (!rx_ready[l]) @(negedge clk);
    @(negedge clk);
    rx_valid[l] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] q; int c;
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 rx_ready", 32'(rx_ready), 0);
    chk("R1 bus_ack", 32'(bus_ack), 0);
    bus(1'b0, 6'h00, '0, q, c);
    chk("R1 ctrl", q, 32'h0000_2132);
    chk("R11 reg ack cycles", 32'(c), 1);
    @(negedge clk);
    chk("R11 ack pulse", 32'(bus_ack), 0);
  endtask

  task automatic t_ctrl;
    logic [31:0] q;
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, q);
    chk("R2 ctrl", q, 32'h8000_2132);
  endtask

  task automatic t_reserved;
    logic [31:0] q;
    wr(6'h08, 32'hDEAD_BEEF);
    wr(6'h10, 32'hFFFF_FFFF);
    for (int k = 1; k < 8; k++) begin
      if (k == 4) continue;
      rd(6'(k * 4), q);
      chk("R3 reserved", q, 0);
    end
  endtask

  task automatic t_tx;
    logic [31:0] q; int c;
    rd(6'h10, q);
    chk("R8 empty status", q, 32'h0000_0700);
    chk("R5 rx_ready empty", 32'(rx_ready), 32'h3);
    wr(6'h24, 32'hA0); wr(6'h24, 32'hA1);
    rd(6'h10, q);
    chk("R8 tx half", q, 32'h0200_0700);
    wr(6'h24, 32'hA2); wr(6'h24, 32'hA3);
    rd(6'h10, q);
    chk("R8 tx full", q, 32'h0200_0500);
    repeat (3) @(negedge clk);
    chk("R4 valid held", 32'(tx_valid), 32'h2);
    chk("R4 data held", tx_data[63:32], 32'hA0);
    fork
      bus(1'b1, 6'h24, 32'hA4, q, c);
      begin
        repeat (4) @(negedge clk);
        tx_ready[1] = 1'b1;
        @(negedge clk);
        tx_ready[1] = 1'b0;
      end
    join
    chk("R7 write stalled", 32'(c >= 4), 1);
    tx_ready[1] = 1'b1;
    for (int k = 1; k < 5; k++) begin
      chk("R4 tx valid", 32'(tx_valid[1]), 1);
      chk("R7 tx order", tx_data[63:32], 32'(8'hA0 + k));
      @(negedge clk);
    end
    tx_ready[1] = 1'b0;
    chk("R4 drained", 32'(tx_valid), 0);
  endtask

  task automatic t_rx;
    logic [31:0] q; int c;
    rx_send(0, 32'hB0);
    rx_send(0, 32'hB1);
    chk("R5 rx full", 32'(rx_ready[0]), 0);
    rd(6'h10, q);
    chk("R8 rx status", q, 32'h0001_0701);
    bus(1'b0, 6'h20, '0, q, c);
    chk("R5 rx first", q, 32'hB0);
    rd(6'h20, q);
    chk("R5 rx second", q, 32'hB1);
    fork
      bus(1'b0, 6'h24, '0, q, c);
      begin
        repeat (5) @(negedge clk);
        rx_valid[1] = 1'b1; rx_data[63:32] = 32'hC5;
        @(negedge clk);
        rx_valid[1] = 1'b0;
      end
    join
    chk("R6 read data", q, 32'hC5);
    chk("R6 read stalled", 32'(c >= 5), 1);
  endtask

  task automatic t_unimpl;
    logic [31:0] q; int c;
    chk("R9 tx_valid high links", 32'(tx_valid[7:3]), 0);
    chk("R9 rx_ready high links", 32'(rx_ready[7:2]), 0);
    chk("R9 tx_data high links", tx_data[191:160], 0);
    bus(1'b1, 6'h34, 32'h1234, q, c);
    chk("R9 tx unimpl ack", 32'(c), 1);
    bus(1'b0, 6'h30, '0, q, c);
    chk("R9 rx unimpl ack", 32'(c), 1);
    chk("R9 rx unimpl data", q, 0);
  endtask

  task automatic t_disable;
    logic [31:0] q; int c;
    wr(6'h20, 32'hD0); wr(6'h20, 32'hD1);
    rx_send(1, 32'hE0);
    wr(6'h00, 32'h0);
    rd(6'h00, q);
    chk("R10 ctrl off", q, 32'h0000_2132);
    chk("R10 tx_valid", 32'(tx_valid), 0);
    chk("R10 rx_ready", 32'(rx_ready), 0);
    bus(1'b0, 6'h24, '0, q, c);
    chk("R10 read ack", 32'(c), 1);
    chk("R10 read data", q, 0);
    bus(1'b1, 6'h20, 32'hD9, q, c);
    chk("R10 write ack", 32'(c), 1);
    wr(6'h00, 32'h8000_0000);
    rd(6'h10, q);
    chk("R10 cleared", q, 32'h0000_0700);
    chk("R10 no tx", 32'(tx_valid), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset(); t_ctrl(); t_reserved(); t_tx(); t_rx(); t_unimpl(); t_disable();
      end
      begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule